// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial bus (I2C-style) placed in front of a byte-wide on-chip memory. The host addresses the block with a device byte. It then sends a two-byte word address and either streams write data or turns the bus around to read. A single transfer can write one byte or a whole page. Reads can start at the current address, at an address just loaded through a dummy write, or run on across many bytes.

Write data is held in a page buffer. It is copied into the array only after the host closes the transfer with a stop condition. The copy runs as a timed internal cycle. For the length of that cycle the block refuses its own device byte, so the host can poll until it is done. A write-protect input throws away write data so the array stays unchanged.

SCL and SDA are oversampled by the system clock. SDA is open-drain: the block only ever pulls it low, through `sda_oe`. The array depth is a parameter. `ARRAY_AW = 14` gives 16,384 bytes in 256 pages of 64 bytes. The default is kept smaller for elaboration.

Top module: `ee2w_slave`

## Requirements
- R1: The device byte is sent MSB first as 1,0,1,0, then the `sel_a1` level, then the `sel_a0` level, then a bit that is ignored, then R/W (1 = read). The block pulls SDA low in the ninth clock only when the bits match. On a mismatch it leaves SDA released and ignores the rest of the transfer.
- R2: The word address follows as two bytes, high byte first. Only the low `ARRAY_AW` bits are used and the upper bits are ignored.
- R3: A byte write (device byte, address, one data byte, stop) stores the byte at the addressed location. Every address and data byte is acknowledged.
- R4: A page write buffers its data bytes. The low 6 address bits advance and wrap within the 64-byte page. A byte sent past the 64th overwrites the buffered byte that sits at the same in-page offset.
- R5: A stop that closes a transfer carrying at least one buffered byte starts an internal write cycle of `TWR_CYC` clocks. During that cycle the device byte is not acknowledged. After the cycle ends it is acknowledged again.
- R6: While `wp_i` is high, data bytes are acknowledged but discarded. The array keeps its contents and no write cycle starts, so the next device byte is acknowledged at once.
- R7: A read that starts with no address phase returns the byte at the address counter. The counter stands one past the last byte read.
- R8: A random read is a dummy write that loads the word address, then a repeated start and a read device byte. It returns the byte at that address.
- R9: A sequential read returns the next byte each time the host acknowledges. After a host not-acknowledge the block releases SDA and stays idle until the next start or stop.
- R10: During reads the address counter wraps from the top array address to 0.
- R11: A start condition arriving in the middle of a transfer, even mid-byte, abandons it. Data already buffered is discarded and the new transfer proceeds normally.
- R12: After reset SDA is released and no write cycle is running.
- R13: The block changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| sel_a0 | input | 1 | Address-select pin compared with device byte bit 2 |
| sel_a1 | input | 1 | Address-select pin compared with device byte bit 3 |
| wp_i | input | 1 | Write protect; high discards write data |

## Verification
SCL and SDA pass through two synchronizer stages and one edge-detect register. Every SDA change the block makes therefore lands about four system clocks after the SCL falling edge that causes it. The bench changes its own SDA one quarter-bit (8 clocks) after each fall and samples the line in the middle of the SCL high phase. Each acknowledge and read bit is read a whole quarter-bit after it becomes due. The array is written `TWR_CYC` clocks after the stop is seen. The bench never waits a fixed time for this: it polls with device bytes, expects at least one refusal, and expects an acknowledge within four attempts before it reads the data back. The bench also samples SDA twice in every SCL high phase to catch a change made while SCL is high.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK, ST_SKIP
  } ee_state_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/ee2w_linemon.sv
module ee2w_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sy[SYNC_STAGES-1];
      sda_d  <= sda_sy[SYNC_STAGES-1];
    end
  end

  assign scl_q     = scl_sy[SYNC_STAGES-1];
  assign sda_q     = sda_sy[SYNC_STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee2w_pagebuf.sv
module ee2w_pagebuf #(
  parameter int AW      = 11,
  parameter int PAGE_AW = 6,
  parameter int TWR_CYC = 800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               load,
  input  logic [PAGE_AW-1:0] idx,
  input  logic [7:0]         data,
  input  logic [AW-PAGE_AW-1:0] page_in,
  input  logic               commit_req,
  output logic               busy,
  output logic               mem_we,
  output logic [AW-1:0]      mem_waddr,
  output logic [7:0]         mem_wdata
);
  // TWR_CYC must be at least PAGE_N so that every offset gets its slot.
  localparam int PAGE_N = 1 << PAGE_AW;
  localparam int PB_W   = AW - PAGE_AW;
  localparam int TW     = $clog2(TWR_CYC + 1);

  logic [7:0]        byte_q [PAGE_N];
  logic [PAGE_N-1:0] mask_q, mask_n;
  logic              busy_q, busy_n;
  logic [TW-1:0]     tmr_q, tmr_n;
  logic [PB_W-1:0]   pbase_q, pbase_n;
  logic [PAGE_AW-1:0] slot;

  always_ff @(posedge clk) begin
    if (load && !busy_q) byte_q[idx] <= data;
  end

  always_comb begin
    mask_n  = mask_q;
    busy_n  = busy_q;
    tmr_n   = tmr_q;
    pbase_n = pbase_q;
    if (busy_q) begin
      if (tmr_q == TW'(TWR_CYC - 1)) begin
        busy_n = 1'b0;
        mask_n = '0;
      end else begin
        tmr_n = tmr_q + 1'b1;
      end
    end else begin
      if (clear) mask_n = '0;
      else if (load) mask_n[idx] = 1'b1;
      if (commit_req && |mask_q) begin
        busy_n  = 1'b1;
        tmr_n   = '0;
        pbase_n = page_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      busy_q  <= 1'b0;
      tmr_q   <= '0;
      pbase_q <= '0;
    end else begin
      mask_q  <= mask_n;
      busy_q  <= busy_n;
      tmr_q   <= tmr_n;
      pbase_q <= pbase_n;
    end
  end

  assign slot      = tmr_q[PAGE_AW-1:0];
  assign busy      = busy_q;
  assign mem_we    = busy_q && (32'(tmr_q) < PAGE_N) && mask_q[slot];
  assign mem_waddr = {pbase_q, slot};
  assign mem_wdata = byte_q[slot];

  assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(commit_req));
endmodule

// File: rtl/ee2w_ctrl.sv
module ee2w_ctrl
  import ee2w_pkg::*;
#(
  parameter int AW      = 11,
  parameter int PAGE_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_q,
  input  logic               sda_q,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sel_a0,
  input  logic               sel_a1,
  input  logic               wp_i,
  input  logic               busy,
  input  logic [7:0]         rd_data,
  output logic [AW-1:0]      rd_addr,
  output logic               buf_load,
  output logic               buf_clear,
  output logic [PAGE_AW-1:0] buf_idx,
  output logic [7:0]         buf_data,
  output logic [AW-PAGE_AW-1:0] buf_page,
  output logic               commit_req,
  output logic               sda_oe
);
  ee_state_e st_q, st_n, ret_q, ret_n;
  logic [3:0]    cnt_q, cnt_n;
  logic [7:0]    sh_q, sh_n, ahi_q, ahi_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          oe_q, oe_n, mack_q, mack_n;
  logic          cnt_full, dev_hit;
  logic [AW-1:0] page_next;

  assign cnt_full  = (cnt_q == 4'd8);
  assign dev_hit   = (sh_q[7:4] == DEV_TYPE) && (sh_q[3] == sel_a1) &&
                     (sh_q[2] == sel_a0) && !busy;
  assign page_next = {addr_q[AW-1:PAGE_AW], addr_q[PAGE_AW-1:0] + PAGE_AW'(1)};

  always_comb begin
    st_n = st_q;  ret_n = ret_q;  cnt_n = cnt_q;  sh_n = sh_q;
    ahi_n = ahi_q;  addr_n = addr_q;  oe_n = oe_q;  mack_n = mack_q;
    buf_load = 1'b0;  buf_clear = 1'b0;  commit_req = 1'b0;
    if (start_det) begin
      st_n = ST_DEV;  cnt_n = '0;  oe_n = 1'b0;  buf_clear = 1'b1;
    end else if (stop_det) begin
      st_n = ST_IDLE;  oe_n = 1'b0;  commit_req = 1'b1;
    end else begin
      unique case (st_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && !cnt_full) begin
            sh_n  = {sh_q[6:0], sda_q};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_full) begin
            cnt_n = '0;
            oe_n  = 1'b1;
            st_n  = ST_ACK;
            case (st_q)
              ST_DEV: begin
                if (dev_hit) ret_n = sh_q[0] ? ST_RDAT : ST_AHI;
                else begin
                  oe_n = 1'b0;
                  st_n = ST_SKIP;
                end
              end
              ST_AHI: begin
                ahi_n = sh_q;
                ret_n = ST_ALO;
              end
              ST_ALO: begin
                addr_n = AW'({ahi_q, sh_q});
                ret_n  = ST_WDAT;
              end
              default: begin
                buf_load = !wp_i;
                addr_n   = page_next;
                ret_n    = ST_WDAT;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_n  = ret_q;
            cnt_n = '0;
            if (ret_q == ST_RDAT) begin
              sh_n   = rd_data;
              oe_n   = ~rd_data[7];
              addr_n = addr_q + 1'b1;
            end else begin
              oe_n = 1'b0;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_full) begin
              oe_n  = 1'b0;
              cnt_n = '0;
              st_n  = ST_RACK;
            end else begin
              sh_n = {sh_q[6:0], 1'b0};
              oe_n = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_q;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (mack_q) begin
              st_n   = ST_RDAT;
              sh_n   = rd_data;
              oe_n   = ~rd_data[7];
              addr_n = addr_q + 1'b1;
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ret_q  <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ahi_q  <= '0;
      addr_q <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ret_q  <= ret_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      ahi_q  <= ahi_n;
      addr_q <= addr_n;
      oe_q   <= oe_n;
      mack_q <= mack_n;
    end
  end

  assign rd_addr  = addr_q;
  assign buf_idx  = addr_q[PAGE_AW-1:0];
  assign buf_data = sh_q;
  assign buf_page = addr_q[AW-1:PAGE_AW];
  assign sda_oe   = oe_q;

  assert_busy_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !oe_q);
  assert_oe_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_q);
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !oe_q);
  assert_bitcnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd8);
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave #(
  parameter int ARRAY_AW    = 11,
  parameter int PAGE_AW     = 6,
  parameter int TWR_CYC     = 800,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic sel_a0,
  input  logic sel_a1,
  input  logic wp_i
);
  localparam int PB_W = ARRAY_AW - PAGE_AW;

  logic [1:0] rs_q;
  logic       rst_ns;
  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic busy, buf_load, buf_clear, commit_req, mem_we;
  logic [PAGE_AW-1:0]  buf_idx;
  logic [7:0]          buf_data, rd_data, mem_wdata;
  logic [PB_W-1:0]     buf_page;
  logic [ARRAY_AW-1:0] rd_addr, mem_waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  ee2w_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_ns), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  ee2w_ctrl #(.AW(ARRAY_AW), .PAGE_AW(PAGE_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sel_a0(sel_a0), .sel_a1(sel_a1), .wp_i(wp_i),
    .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .buf_load(buf_load),
    .buf_clear(buf_clear), .buf_idx(buf_idx), .buf_data(buf_data),
    .buf_page(buf_page), .commit_req(commit_req), .sda_oe(sda_oe));

  ee2w_pagebuf #(.AW(ARRAY_AW), .PAGE_AW(PAGE_AW), .TWR_CYC(TWR_CYC)) u_pbuf (
    .clk(clk), .rst_n(rst_ns), .clear(buf_clear), .load(buf_load),
    .idx(buf_idx), .data(buf_data), .page_in(buf_page),
    .commit_req(commit_req), .busy(busy), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  ee2w_array #(.AW(ARRAY_AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data));
endmodule

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int Q = 8;

  logic clk, rst_n, m_scl, m_sda, sel_a0, sel_a1, wp;
  wire  sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int n_cmp = 0, n_bad = 0, n_glitch = 0;
  logic [7:0] model [DEPTH];
  bit         known [DEPTH];
  logic [7:0] pay   [128];
  logic [7:0] rbuf  [128];

  ee2w_slave u_dut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .sel_a0(sel_a0), .sel_a1(sel_a1), .wp_i(wp));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq(1); m_scl = 1'b1; waitq(1);
    m_sda = 1'b0; waitq(1); m_scl = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(1); m_scl = 1'b1; waitq(1);
    m_sda = 1'b1; waitq(2);
  endtask

  task automatic bit_io(input bit b, output bit r);
    bit r2;
    m_sda = b; waitq(1); m_scl = 1'b1; waitq(1);
    r = sda_line;
    repeat (Q - 1) @(negedge clk);
    r2 = sda_line;
    if (r2 != r) n_glitch++;
    @(negedge clk); m_scl = 1'b0; waitq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); b[i] = r; end
    bit_io(!mack, r);
  endtask

  function automatic logic [7:0] devb(input bit rd);
    return {4'b1010, sel_a1, sel_a0, 1'b0, rd};
  endfunction

  function automatic int map_addr(input logic [15:0] a, input int i);
    return {a[AW-1:6], 6'((a[5:0] + i) % 64)};
  endfunction

  task automatic write_tx(input logic [15:0] a, input int n, input string tag);
    bit ack, all_ack;
    all_ack = 1'b1;
    bus_start();
    send_byte(devb(1'b0), ack); all_ack &= ack;
    send_byte(a[15:8], ack);    all_ack &= ack;
    send_byte(a[7:0], ack);     all_ack &= ack;
    for (int i = 0; i < n; i++) begin send_byte(pay[i], ack); all_ack &= ack; end
    bus_stop();
    chk(all_ack, tag, all_ack, 1);
    if (!wp)
      for (int i = 0; i < n; i++) begin
        model[map_addr(a, i)] = pay[i];
        known[map_addr(a, i)] = 1'b1;
      end
  endtask

  task automatic poll(output int tries);
    bit ack;
    tries = 0;
    for (int k = 0; k < 20; k++) begin
      bus_start();
      send_byte(devb(1'b0), ack);
      bus_stop();
      if (ack) break;
      tries++;
    end
  endtask

  task automatic wait_done(input string tag);
    int t;
    poll(t);
    chk(t >= 1 && t <= 4, tag, t, 2);
  endtask

  task automatic fetch(input int n);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    chk(sda_oe == 1'b0, "R9 release after host NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string tag);
    bit ack, all_ack;
    all_ack = 1'b1;
    bus_start();
    send_byte(devb(1'b0), ack); all_ack &= ack;
    send_byte(a[15:8], ack);    all_ack &= ack;
    send_byte(a[7:0], ack);     all_ack &= ack;
    bus_start();
    send_byte(devb(1'b1), ack); all_ack &= ack;
    chk(all_ack, "R8 dummy write acks", all_ack, 1);
    fetch(n);
    for (int k = 0; k < n; k++) begin
      int ad;
      ad = (int'(a[AW-1:0]) + k) % DEPTH;
      if (known[ad]) chk(rbuf[k] == model[ad], tag, rbuf[k], model[ad]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit ack;
    int t;
    void'($urandom(32'h1DEA5));
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; sel_a1 = 1'b1; sel_a0 = 1'b0; wp = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R12: reset state
    chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
    poll(t);
    chk(t == 0, "R12 not busy after reset", t, 0);

    // R1: address decode
    bus_start(); send_byte({4'b1010, ~sel_a1, sel_a0, 2'b00}, ack); bus_stop();
    chk(!ack, "R1 sel_a1 mismatch NACK", ack, 0);
    bus_start(); send_byte({4'b1010, sel_a1, ~sel_a0, 2'b00}, ack); bus_stop();
    chk(!ack, "R1 sel_a0 mismatch NACK", ack, 0);
    bus_start(); send_byte({4'b1011, sel_a1, sel_a0, 2'b00}, ack); bus_stop();
    chk(!ack, "R1 type mismatch NACK", ack, 0);
    bus_start(); send_byte({4'b1010, sel_a1, sel_a0, 2'b10}, ack); bus_stop();
    chk(ack, "R1 ignored bit set ACK", ack, 1);

    // R3: byte write, R5 polling, R8 random read
    pay[0] = 8'h5A;
    write_tx(16'h0123, 1, "R3 byte write acks");
    wait_done("R5 poll after byte write");
    rand_read(16'h0123, 1, "R3 byte readback");

    // R2: upper word-address bits ignored
    pay[0] = 8'hC3;
    write_tx(16'hF8A5, 1, "R2 write acks");
    wait_done("R5 poll R2");
    rand_read(16'h00A5, 1, "R2 aliased address");

    // R4: page write with in-page wrap, then full-page sequential read
    for (int i = 0; i < 40; i++) pay[i] = 8'($urandom);
    write_tx(16'h0230, 40, "R4 page write acks");
    wait_done("R5 poll page");
    rand_read(16'h0200, 64, "R4 page wrap readback R9");

    // R4: overflow past 64 bytes
    for (int i = 0; i < 66; i++) pay[i] = 8'($urandom);
    write_tx(16'h0300, 66, "R4 overflow acks");
    wait_done("R5 poll overflow");
    rand_read(16'h0300, 4, "R4 overflow overwrite");

    // R6: write protect
    wp = 1'b1;
    pay[0] = ~model[12'h300]; pay[1] = ~model[12'h301];
    write_tx(16'h0300, 2, "R6 data acked under WP");
    poll(t);
    chk(t == 0, "R6 no write cycle", t, 0);
    wp = 1'b0;
    rand_read(16'h0300, 2, "R6 array unchanged");

    // R7: current-address read continues at 0x302
    bus_start(); send_byte(devb(1'b1), ack);
    chk(ack, "R7 read device ACK", ack, 1);
    fetch(1);
    chk(rbuf[0] == model[12'h302], "R7 current address", rbuf[0], model[12'h302]);

    // R10: wrap from top address
    pay[0] = 8'hA1; pay[1] = 8'hB2;
    write_tx(16'h07FE, 2, "R10 write top");
    wait_done("R5 poll top");
    pay[0] = 8'h3C;
    write_tx(16'h0000, 1, "R10 write zero");
    wait_done("R5 poll zero");
    rand_read(16'h07FE, 3, "R10 wrap read");

    // R11: start mid-transfer
    pay[0] = 8'h11;
    write_tx(16'h0400, 1, "R11 seed write");
    wait_done("R5 poll seed");
    bus_start();
    send_byte(devb(1'b0), ack); send_byte(8'h04, ack); send_byte(8'h00, ack);
    send_byte(8'h99, ack);
    chk(ack, "R11 aborted data acked", ack, 1);
    bus_start();
    send_byte(devb(1'b0), ack); send_byte(8'h04, ack);
    bit_io(1'b0, ack); bit_io(1'b1, ack); bit_io(1'b1, ack);
    pay[0] = 8'h77;
    write_tx(16'h0410, 1, "R11 fresh transfer acks");
    wait_done("R5 poll R11");
    rand_read(16'h0400, 1, "R11 aborted byte discarded");
    rand_read(16'h0410, 1, "R11 new write stored");

    // random mix
    for (int it = 0; it < 8; it++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom);
      n = 1 + int'($urandom % 5);
      if ($urandom % 2 == 0) begin
        for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
        write_tx(a, n, "R3 random write acks");
        wait_done("R5 random poll");
        rand_read({a[15:6], 6'(a[5:0])}, 1, "R4 random readback");
      end else begin
        rand_read(a, n, "R9 random sequential read");
      end
    end

    chk(n_glitch == 0, "R13 SDA stable while SCL high", n_glitch, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule